// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a small device. A test clock, a mode-select line, a serial data input and a serial data output, plus a synchronous reset, give an external tester control of a sixteen-state controller. Through that controller the tester loads an eight-bit instruction and then shifts data through the data register that the instruction selects. The data register is one of three: a one-bit bypass stage, a 32-bit device identification word, or a boundary chain of configurable length.

The boundary chain sits between the core's pin-side outputs and the pads. In normal operation each pad follows its core signal. Some instructions hand the pads to the chain's update latches instead. A tester can then drive board nets from a shifted pattern, or hold the pads at a known state while it talks to the short bypass path. It can also snapshot live pin values without disturbing the core.

Top module: `jtag_tap`

## Requirements
- R1: The controller has sixteen states and uses the standard scan-port transition graph. TMS is sampled on each rising TCK edge. From any state, five consecutive high TMS samples reach Test-Logic-Reset.
- R2: While `tap_rst` is high at a rising TCK edge, the controller enters Test-Logic-Reset and IDCODE becomes the active instruction. While it is high at a falling edge, `tdo_oe` clears. This applies even when the reset arrives in the middle of a shift.
- R3: The instruction register is 8 bits wide and is shifted least significant bit first. In Capture-IR it loads 0x01, so the two low bits read out as 1 then 0. The shifted value becomes the active instruction in Update-IR.
- R4: Every pass through Test-Logic-Reset makes IDCODE (0x0F) active. Under IDCODE, Capture-DR loads the 32-bit identification parameter with bit 0 forced to 1, and Shift-DR sends it out least significant bit first.
- R5: BYPASS (0xFF), and every opcode other than 0x00, 0x01, 0x05 and 0x0F, selects a one-bit register. That register captures 0 and delays TDI by one shift.
- R6: CLAMP (0x05) selects the one-bit bypass register as the data path. It also drives the pads from the boundary update latches.
- R7: SAMPLE/PRELOAD (0x01) selects the boundary chain. Capture-DR loads `core_pin_i` into the chain, and pin 0 leaves first. The pads keep following `core_pin_i`, even after Update-DR loads the latches.
- R8: EXTEST (0x00) selects the boundary chain and drives the pads from the update latches. After Update-DR, pad j carries the bit that was shifted into chain cell j.
- R9: TDO changes only on falling TCK edges. `tdo_oe` is high only for the half-cycles that follow a falling edge taken in Shift-IR or Shift-DR.
- R10: The boundary update latches change only in Update-DR while EXTEST or SAMPLE/PRELOAD is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge, TDO on its falling edge |
| tap_rst | input | 1 | Synchronous active-high reset of the port |
| tms | input | 1 | Mode select sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Output enable for TDO (low means high-impedance) |
| core_pin_i | input | PIN_CNT | Values the core presents to its pads |
| pad_o | output | PIN_CNT | Values driven onto the pads |

## Verification
A wrong controller state shows up at the ports within one falling edge. `tdo_oe` rises where it should stay low, or the captured pattern is misaligned, so the bits read out shift by one or more positions against the bits expected. A wrong decoded instruction shows up within one data scan. The scan length is wrong, so identification bits or delayed TDI bits appear in the wrong places, and the pads switch to or from the latches the moment Update-IR completes. A stray latch update shows up at the pads in the first Run-Test/Idle cycle under EXTEST or CLAMP. The sweep visits every one of the 256 opcodes and every controller state for this reason.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    localparam int IR_W = 8;

    localparam logic [IR_W-1:0] OP_EXTEST  = 8'h00;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 8'h01;
    localparam logic [IR_W-1:0] OP_CLAMP   = 8'h05;
    localparam logic [IR_W-1:0] OP_IDCODE  = 8'h0F;
    localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;

    localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

    typedef enum logic [3:0] {
        ST_EXIT2_DR   = 4'h0,
        ST_EXIT1_DR   = 4'h1,
        ST_SHIFT_DR   = 4'h2,
        ST_PAUSE_DR   = 4'h3,
        ST_SELECT_IR  = 4'h4,
        ST_UPDATE_DR  = 4'h5,
        ST_CAPTURE_DR = 4'h6,
        ST_SELECT_DR  = 4'h7,
        ST_EXIT2_IR   = 4'h8,
        ST_EXIT1_IR   = 4'h9,
        ST_SHIFT_IR   = 4'hA,
        ST_PAUSE_IR   = 4'hB,
        ST_RUN_IDLE   = 4'hC,
        ST_UPDATE_IR  = 4'hD,
        ST_CAPTURE_IR = 4'hE,
        ST_TEST_RESET = 4'hF
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS   = 2'd0,
        DR_IDENT    = 2'd1,
        DR_BOUNDARY = 2'd2
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e dr_sel;
        logic    pads_from_latch;
        logic    chain_active;
    } instr_decode_t;

    typedef struct packed {
        logic test_reset;
        logic capture_dr;
        logic shift_dr;
        logic update_dr;
        logic capture_ir;
        logic shift_ir;
        logic update_ir;
    } tap_ctrl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_TEST_RESET: n = m ? ST_TEST_RESET : ST_RUN_IDLE;
            ST_RUN_IDLE:   n = m ? ST_SELECT_DR  : ST_RUN_IDLE;
            ST_SELECT_DR:  n = m ? ST_SELECT_IR  : ST_CAPTURE_DR;
            ST_CAPTURE_DR: n = m ? ST_EXIT1_DR   : ST_SHIFT_DR;
            ST_SHIFT_DR:   n = m ? ST_EXIT1_DR   : ST_SHIFT_DR;
            ST_EXIT1_DR:   n = m ? ST_UPDATE_DR  : ST_PAUSE_DR;
            ST_PAUSE_DR:   n = m ? ST_EXIT2_DR   : ST_PAUSE_DR;
            ST_EXIT2_DR:   n = m ? ST_UPDATE_DR  : ST_SHIFT_DR;
            ST_UPDATE_DR:  n = m ? ST_SELECT_DR  : ST_RUN_IDLE;
            ST_SELECT_IR:  n = m ? ST_TEST_RESET : ST_CAPTURE_IR;
            ST_CAPTURE_IR: n = m ? ST_EXIT1_IR   : ST_SHIFT_IR;
            ST_SHIFT_IR:   n = m ? ST_EXIT1_IR   : ST_SHIFT_IR;
            ST_EXIT1_IR:   n = m ? ST_UPDATE_IR  : ST_PAUSE_IR;
            ST_PAUSE_IR:   n = m ? ST_EXIT2_IR   : ST_PAUSE_IR;
            ST_EXIT2_IR:   n = m ? ST_UPDATE_IR  : ST_SHIFT_IR;
            ST_UPDATE_IR:  n = m ? ST_SELECT_DR  : ST_RUN_IDLE;
            default:       n = ST_TEST_RESET;
        endcase
        return n;
    endfunction

    function automatic instr_decode_t decode_op(input logic [IR_W-1:0] op);
        instr_decode_t d;
        case (op)
            OP_EXTEST: d = '{dr_sel: DR_BOUNDARY, pads_from_latch: 1'b1, chain_active: 1'b1};
            OP_SAMPLE: d = '{dr_sel: DR_BOUNDARY, pads_from_latch: 1'b0, chain_active: 1'b1};
            OP_CLAMP:  d = '{dr_sel: DR_BYPASS,   pads_from_latch: 1'b1, chain_active: 1'b0};
            OP_IDCODE: d = '{dr_sel: DR_IDENT,    pads_from_latch: 1'b0, chain_active: 1'b0};
            default:   d = '{dr_sel: DR_BYPASS,   pads_from_latch: 1'b0, chain_active: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state,
    output tap_ctrl_t  ctrl
);

    tap_state_e state_q;

    always_ff @(posedge tck) begin
        if (rst) state_q <= ST_TEST_RESET;
        else     state_q <= tap_next(state_q, tms);
    end

    always_comb begin
        ctrl            = '0;
        ctrl.test_reset = (state_q == ST_TEST_RESET);
        ctrl.capture_dr = (state_q == ST_CAPTURE_DR);
        ctrl.shift_dr   = (state_q == ST_SHIFT_DR);
        ctrl.update_dr  = (state_q == ST_UPDATE_DR);
        ctrl.capture_ir = (state_q == ST_CAPTURE_IR);
        ctrl.shift_ir   = (state_q == ST_SHIFT_IR);
        ctrl.update_ir  = (state_q == ST_UPDATE_IR);
    end

    assign state = state_q;

    // R1
    five_ones_reset_chk: assert property (@(posedge tck) disable iff (rst)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state_q == ST_TEST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic          tck,
    input  logic          rst,
    input  logic          tdi,
    input  tap_ctrl_t     ctrl,
    output logic          ir_bit,
    output instr_decode_t dec
);

    logic [IR_W-1:0] shreg_q;
    logic [IR_W-1:0] active_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            shreg_q  <= '0;
            active_q <= OP_IDCODE;
        end else begin
            if (ctrl.capture_ir)    shreg_q <= IR_CAPTURE;
            else if (ctrl.shift_ir) shreg_q <= {tdi, shreg_q[IR_W-1:1]};
            if (ctrl.test_reset)     active_q <= OP_IDCODE;
            else if (ctrl.update_ir) active_q <= shreg_q;
        end
    end

    assign ir_bit = shreg_q[0];
    assign dec    = decode_op(active_q);

    // R3
    ir_capture_pattern_chk: assert property (@(posedge tck) disable iff (rst)
        ctrl.capture_ir |=> (shreg_q[1:0] == 2'b01));

    // R3
    ir_update_transfer_chk: assert property (@(posedge tck) disable iff (rst)
        ctrl.update_ir |=> (active_q == $past(shreg_q)));

    // R4
    ir_reset_idcode_chk: assert property (@(posedge tck) disable iff (rst)
        ctrl.test_reset |=> (active_q == OP_IDCODE));

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr #(
    parameter int PIN_CNT = 8
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tdi,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               update_en,
    input  logic               pads_from_latch,
    input  logic [PIN_CNT-1:0] core_pin_i,
    output logic [PIN_CNT-1:0] pad_o,
    output logic               chain_bit
);

    logic [PIN_CNT-1:0] chain_q;
    logic [PIN_CNT-1:0] latch_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            chain_q <= '0;
            latch_q <= '0;
        end else begin
            if (capture_en)    chain_q <= core_pin_i;
            else if (shift_en) chain_q <= {tdi, chain_q[PIN_CNT-1:1]};
            if (update_en)     latch_q <= chain_q;
        end
    end

    for (genvar j = 0; j < PIN_CNT; j++) begin : g_cell
        assign pad_o[j] = pads_from_latch ? latch_q[j] : core_pin_i[j];
    end

    assign chain_bit = chain_q[0];

    // R10
    latch_hold_chk: assert property (@(posedge tck) disable iff (rst)
        !update_en |=> $stable(latch_q));

    // R7
    chain_capture_chk: assert property (@(posedge tck) disable iff (rst)
        capture_en |=> (chain_q == $past(core_pin_i)));

endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
    import jtag_tap_pkg::*;
#(
    parameter int          PIN_CNT  = 8,
    parameter logic [31:0] ID_VALUE = 32'h4B7A_1093
) (
    input  logic               tck,
    input  logic               tap_rst,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic [PIN_CNT-1:0] core_pin_i,
    output logic [PIN_CNT-1:0] pad_o
);

    localparam int          ID_W       = 32;
    localparam logic [ID_W-1:0] ID_CAPTURE = ID_VALUE | 32'h1;

    tap_state_e    state;
    tap_ctrl_t     ctrl;
    instr_decode_t dec;
    logic          ir_bit;
    logic          chain_bit;
    logic          dr_bit;
    logic          bypass_q;
    logic [ID_W-1:0] id_q;
    logic          sel_id;
    logic          sel_chain;
    logic          sel_byp;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (tap_rst),
        .tms   (tms),
        .state (state),
        .ctrl  (ctrl)
    );

    tap_ir u_ir (
        .tck    (tck),
        .rst    (tap_rst),
        .tdi    (tdi),
        .ctrl   (ctrl),
        .ir_bit (ir_bit),
        .dec    (dec)
    );

    assign sel_id    = (dec.dr_sel == DR_IDENT);
    assign sel_chain = (dec.dr_sel == DR_BOUNDARY);
    assign sel_byp   = (dec.dr_sel == DR_BYPASS);

    tap_bsr #(.PIN_CNT(PIN_CNT)) u_bsr (
        .tck             (tck),
        .rst             (tap_rst),
        .tdi             (tdi),
        .capture_en      (ctrl.capture_dr && dec.chain_active),
        .shift_en        (ctrl.shift_dr && sel_chain),
        .update_en       (ctrl.update_dr && dec.chain_active),
        .pads_from_latch (dec.pads_from_latch),
        .core_pin_i      (core_pin_i),
        .pad_o           (pad_o),
        .chain_bit       (chain_bit)
    );

    always_ff @(posedge tck) begin
        if (tap_rst) begin
            bypass_q <= 1'b0;
            id_q     <= '0;
        end else begin
            if (ctrl.capture_dr)                bypass_q <= 1'b0;
            else if (ctrl.shift_dr && sel_byp)  bypass_q <= tdi;
            if (ctrl.capture_dr && sel_id)      id_q <= ID_CAPTURE;
            else if (ctrl.shift_dr && sel_id)   id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    always_comb begin
        case (dec.dr_sel)
            DR_IDENT:    dr_bit = id_q[0];
            DR_BOUNDARY: dr_bit = chain_bit;
            default:     dr_bit = bypass_q;
        endcase
    end

    always_ff @(negedge tck) begin
        if (tap_rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= ctrl.shift_ir || ctrl.shift_dr;
            tdo    <= ctrl.shift_ir ? ir_bit : dr_bit;
        end
    end

    // R9
    tdo_enable_window_chk: assert property (@(posedge tck) disable iff (tap_rst)
        tdo_oe |-> (state == ST_SHIFT_IR || state == ST_SHIFT_DR));

    // R5
    bypass_delay_chk: assert property (@(posedge tck) disable iff (tap_rst)
        (ctrl.shift_dr && sel_byp) |=> (bypass_q == $past(tdi)));

    // R4
    id_capture_lsb_chk: assert property (@(posedge tck) disable iff (tap_rst)
        (ctrl.capture_dr && sel_id) |=> id_q[0]);

endmodule

// File: tb/jtag_tap_tb.sv
module jtag_tap_tb;

    localparam int          N      = 8;
    localparam logic [31:0] ID_RAW = 32'h2C61_90A4;
    localparam logic [31:0] ID_EXP = 32'h2C61_90A5;

    logic         tck = 1'b0;
    logic         tap_rst = 1'b1;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic         tdo;
    logic         tdo_oe;
    logic [N-1:0] core_pin_i = '0;
    logic [N-1:0] pad_o;

    int tests = 0;
    int fails = 0;
    logic [N-1:0] lat_model = '0;

    always #5 tck = ~tck;

    jtag_tap #(.PIN_CNT(N), .ID_VALUE(ID_RAW)) u_dut (
        .tck        (tck),
        .tap_rst    (tap_rst),
        .tms        (tms),
        .tdi        (tdi),
        .tdo        (tdo),
        .tdo_oe     (tdo_oe),
        .core_pin_i (core_pin_i),
        .pad_o      (pad_o)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic d, output logic o, output logic oe);
        tms = t;
        tdi = d;
        @(negedge tck);
        #1;
        o  = tdo;
        oe = tdo_oe;
        @(posedge tck);
        #1;
    endtask

    task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap);
        logic o, oe, all_oe;
        all_oe = 1'b1;
        step(1, 0, o, oe); step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, op[i], o, oe);
            cap[i] = o;
            all_oe &= oe;
        end
        step(1, 0, o, oe); step(0, 0, o, oe);
        chk(all_oe, "R9 oe in Shift-IR", 64'(all_oe), 64'h1);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o, oe, all_oe;
        all_oe = 1'b1;
        dout = '0;
        step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, oe);
            dout[i] = o;
            all_oe &= oe;
        end
        step(1, 0, o, oe); step(0, 0, o, oe);
        chk(all_oe, "R9 oe in Shift-DR", 64'(all_oe), 64'h1);
    endtask

    task automatic tap_reset_idle();
        logic o, oe;
        for (int i = 0; i < 5; i++) step(1, 0, o, oe);
        step(0, 0, o, oe);
    endtask

    function automatic void path_to(input int s, output logic [7:0] b, output int len);
        case (s)
            0:  begin b = 8'd0;  len = 0; end
            1:  begin b = 8'd1;  len = 1; end
            2:  begin b = 8'd1;  len = 2; end
            3:  begin b = 8'd1;  len = 3; end
            4:  begin b = 8'd5;  len = 3; end
            5:  begin b = 8'd5;  len = 4; end
            6:  begin b = 8'd21; len = 5; end
            7:  begin b = 8'd13; len = 4; end
            8:  begin b = 8'd3;  len = 2; end
            9:  begin b = 8'd3;  len = 3; end
            10: begin b = 8'd3;  len = 4; end
            11: begin b = 8'd11; len = 4; end
            12: begin b = 8'd11; len = 5; end
            13: begin b = 8'd43; len = 6; end
            14: begin b = 8'd27; len = 5; end
            default: begin b = 8'd7; len = 3; end
        endcase
    endfunction

    initial begin
        #2_000_000;
        fails++;
        tests++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0]  cap;
        logic [63:0] dout, pat, expv;
        logic        o, oe;
        int          len;
        logic [63:0] capv;

        core_pin_i = 8'h6B;
        repeat (3) @(posedge tck);
        #1;
        tap_rst = 1'b0;
        @(negedge tck);
        #1;
        chk(tdo_oe == 1'b0, "R2 oe after reset", 64'(tdo_oe), 64'h0);
        chk(pad_o == core_pin_i, "R2 pads follow core after reset", 64'(pad_o), 64'(core_pin_i));
        @(posedge tck);
        #1;
        step(0, 0, o, oe);

        // R4: identification read straight after reset, bit 0 forced
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == ID_EXP, "R4 id after reset", dout, 64'(ID_EXP));

        // Sweep of every opcode: R3 capture, R5/R6/R7/R8 path and pads, R10 latch
        for (int opi = 0; opi < 256; opi++) begin
            logic [7:0] op;
            op = 8'(opi);
            core_pin_i = op ^ 8'h9C;
            scan_ir(op, cap);
            chk(cap == 8'h01, "R3 Capture-IR pattern", 64'(cap), 64'h01);
            pat = {24'h0, op ^ 8'hA5, op, op + 8'h37, ~op, op ^ 8'h3C};
            if (op == 8'h00 || op == 8'h01) begin len = N; capv = 64'(core_pin_i); end
            else if (op == 8'h0F)           begin len = 32; capv = 64'(ID_EXP); end
            else                            begin len = 1; capv = 64'h0; end
            scan_dr(40, pat, dout);
            expv = '0;
            for (int i = 0; i < 40; i++) expv[i] = (i < len) ? capv[i] : pat[i - len];
            chk(dout == expv, (op == 8'h00) ? "R8 EXTEST path" : (op == 8'h01) ? "R7 SAMPLE path" :
                (op == 8'h05) ? "R6 CLAMP bypass path" : (op == 8'h0F) ? "R4 IDCODE path" :
                "R5 bypass path", dout, expv);
            if (op == 8'h00 || op == 8'h01)
                for (int j = 0; j < N; j++) lat_model[j] = pat[40 - N + j];
            if (op == 8'h00 || op == 8'h05)
                chk(pad_o == lat_model, (op == 8'h00) ? "R8 pads from latches" : "R6 R10 clamp pads",
                    64'(pad_o), 64'(lat_model));
            else
                chk(pad_o == core_pin_i, "R7 R5 pads follow core", 64'(pad_o), 64'(core_pin_i));
        end

        // R7: SAMPLE keeps pads live on core changes after update
        scan_ir(8'h01, cap);
        core_pin_i = 8'h5A;
        step(0, 0, o, oe);
        chk(pad_o == 8'h5A, "R7 pads live under SAMPLE", 64'(pad_o), 64'h5A);
        chk(tdo_oe == 1'b0, "R9 oe low in idle", 64'(tdo_oe), 64'h0);

        // R1: five TMS highs from each of the sixteen states
        for (int s = 0; s < 16; s++) begin
            logic [7:0] b;
            int n;
            scan_ir(8'hFF, cap);
            path_to(s, b, n);
            for (int k = 0; k < n; k++) step(b[k], 0, o, oe);
            tap_reset_idle();
            scan_dr(32, 64'h0, dout);
            chk(dout[31:0] == ID_EXP, "R1 five-high reset from state", dout, 64'(ID_EXP));
        end

        // R2: synchronous reset in the middle of Shift-DR
        scan_ir(8'hFF, cap);
        step(1, 0, o, oe); step(0, 0, o, oe); step(0, 1, o, oe);
        tap_rst = 1'b1;
        @(negedge tck);
        #1;
        chk(tdo_oe == 1'b0, "R2 oe cleared by reset", 64'(tdo_oe), 64'h0);
        @(posedge tck);
        #1;
        tap_rst = 1'b0;
        step(0, 0, o, oe);
        scan_dr(32, 64'h0, dout);
        chk(dout[31:0] == ID_EXP, "R2 IDCODE after reset", dout, 64'(ID_EXP));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule